// File: doc/BRIEF.md
# Dual-Source JTAG Test Access Port

This block is a test access port for one die that sits with other dies on a single scan chain inside a package. It runs the usual sixteen-state TAP controller from TMS and TCK and drives TDO through an enable. It also holds a 4-bit instruction register, a 1-bit bypass register, a 32-bit identification register and an 8-bit user data register.

Besides the chained serial input `tdi_i`, the die has a second serial input, `stdi_i`, which the package ties to its own top-level data input. Instructions always enter through `tdi_i`, so the package-level instruction register is the chain of all dies' instruction registers. The bypass and identification registers shift from `stdi_i` instead. When every die selects one of these registers, only the register of the last die in the chain sits between the package pins, and the package then looks like a single device.

A separate output provides an active-low test reset for a neighbouring legacy die that has no such input. This output is released a fixed number of TCK cycles after power-on reset. It serves test reset only.

Top module: `dtap_top`

## Requirements
- R1: Five consecutive TCK rising edges with TMS high put the controller in Test-Logic-Reset from any state. In that state the current instruction becomes IDCODE (4'b0001), so a data scan that follows returns the identification value.
- R2: Driving `trst_ni` low forces Test-Logic-Reset at once, without a TCK edge. It also clears `tdo_en_o` and the user register, and leaves IDCODE as the instruction.
- R3: Capture-IR loads 4'b0001, which is shifted out least significant bit first. Instruction shifting takes its bits from `tdi_i` only, and `stdi_i` has no effect on it.
- R4: Under IDCODE (4'b0001), Capture-DR loads the 32-bit `ID_VALUE`, which is shifted out least significant bit first. The bits shifted in are taken from `stdi_i`, so after 32 shifts the `stdi_i` stream appears on TDO and `tdi_i` has no effect.
- R5: Under BYPASS (4'b1111), the 1-bit bypass register captures 0 and then gives a one-bit delay from `stdi_i` to TDO. `tdi_i` has no effect.
- R6: Every code other than 4'b0001 and 4'b0010 behaves exactly as BYPASS.
- R7: Under USERDR (4'b0010), an 8-bit register shifts from `tdi_i`. Capture-DR loads the value currently held on `user_dr_o`, and Update-DR copies the shifted contents to `user_dr_o`.
- R8: `tdo_en_o` is high only while the controller is in Shift-IR or Shift-DR. TDO and its enable change on the falling edge of TCK.
- R9: `por_trst_no` stays low while `rst_ni` is low and for `POR_CYCLES` (8) rising TCK edges after `rst_ni` is released, and is high after that. `trst_ni` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| trst_ni | input | 1 | Test reset, active low, asynchronous |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Chained serial input (instructions, user register) |
| stdi_i | input | 1 | Package-level serial input (bypass, identification) |
| tdo_o | output | 1 | Serial output |
| tdo_en_o | output | 1 | Output enable for TDO |
| user_dr_o | output | USER_W | Updated user register value |
| por_trst_no | output | 1 | Test reset for a legacy die, active low |

## Verification
The assertions assume that TMS and both serial inputs are stable around each rising TCK edge. They also assume that `trst_ni` and `rst_ni` are only asserted and released while TCK is low. The power-on-reset window check further assumes that TCK runs after `rst_ni` is released. The bench meets these assumptions by changing every input only while TCK is low, half a period away from the rising edge. It sweeps all sixteen instruction codes, and for each code it shifts 48 bits with distinct patterns on the two serial inputs. This makes any mistake in source selection visible in the TDO stream.

// File: rtl/dtap_pkg.sv
package dtap_pkg;
  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  localparam int unsigned IR_W = 4;
  localparam logic [IR_W-1:0] INS_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] INS_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] INS_USER   = 4'b0010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_USR} dr_sel_e;
endpackage

// File: rtl/dtap_fsm.sv
module dtap_fsm
  import dtap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_TLR:    state_d = tms_i ? S_TLR    : S_RTI;
      S_RTI:    state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_DR: state_d = tms_i ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  state_d = tms_i ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: state_d = tms_i ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: state_d = tms_i ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: state_d = tms_i ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: state_d = tms_i ? S_SEL_DR : S_RTI;
      S_SEL_IR: state_d = tms_i ? S_TLR    : S_CAP_IR;
      S_CAP_IR: state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  state_d = tms_i ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: state_d = tms_i ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: state_d = tms_i ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: state_d = tms_i ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: state_d = tms_i ? S_SEL_DR : S_RTI;
      default:  state_d = S_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dtap_ir.sv
module dtap_ir
  import dtap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_sr_o,
  output logic [IR_W-1:0] ir_o
);
  logic [IR_W-1:0] sr_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= IR_CAPTURE;
      ir_q <= INS_IDCODE;
    end else begin
      unique case (state_i)
        S_TLR:    ir_q <= INS_IDCODE;
        S_CAP_IR: sr_q <= IR_CAPTURE;
        S_SH_IR:  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        S_UPD_IR: ir_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign ir_sr_o = sr_q;
  assign ir_o    = ir_q;
endmodule

// File: rtl/dtap_dr.sv
module dtap_dr
  import dtap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1A5C_E0F3,
  parameter int unsigned USER_W   = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic [IR_W-1:0]   ir_i,
  input  logic              tdi_i,
  input  logic              stdi_i,
  output logic              dr_lsb_o,
  output logic [USER_W-1:0] user_o
);
  localparam int unsigned ID_W = 32;

  dr_sel_e           sel;
  logic              ser_in;
  logic              byp_q;
  logic [ID_W-1:0]   id_sr;
  logic [USER_W-1:0] usr_sr, usr_q;

  always_comb begin
    unique case (ir_i)
      INS_IDCODE: sel = DR_ID;
      INS_USER:   sel = DR_USR;
      default:    sel = DR_BYP;
    endcase
  end

  // user register stays on the die chain; bypass and ID take the package input
  assign ser_in = (sel == DR_USR) ? tdi_i : stdi_i;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      id_sr  <= ID_VALUE;
      usr_sr <= '0;
      usr_q  <= '0;
    end else begin
      unique case (state_i)
        S_CAP_DR: begin
          unique case (sel)
            DR_ID:   id_sr  <= ID_VALUE;
            DR_USR:  usr_sr <= usr_q;
            default: byp_q  <= 1'b0;
          endcase
        end
        S_SH_DR: begin
          unique case (sel)
            DR_ID:   id_sr  <= {ser_in, id_sr[ID_W-1:1]};
            DR_USR:  usr_sr <= {ser_in, usr_sr[USER_W-1:1]};
            default: byp_q  <= ser_in;
          endcase
        end
        S_UPD_DR: if (sel == DR_USR) usr_q <= usr_sr;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      DR_ID:   dr_lsb_o = id_sr[0];
      DR_USR:  dr_lsb_o = usr_sr[0];
      default: dr_lsb_o = byp_q;
    endcase
  end

  assign user_o = usr_q;
endmodule

// File: rtl/dtap_por.sv
module dtap_por #(
  parameter int unsigned POR_CYCLES = 8
) (
  input  logic tck_i,
  input  logic rst_ni,
  output logic por_trst_no
);
  localparam int unsigned CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POR_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign por_trst_no = (cnt_q == CNT_MAX);
endmodule

// File: rtl/dtap_top.sv
module dtap_top
  import dtap_pkg::*;
#(
  parameter logic [31:0] ID_VALUE   = 32'h1A5C_E0F3,
  parameter int unsigned USER_W     = 8,
  parameter int unsigned POR_CYCLES = 8
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              trst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  input  logic              stdi_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  output logic [USER_W-1:0] user_dr_o,
  output logic              por_trst_no
);
  logic            tap_rst_n;
  tap_state_e      state;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic            dr_lsb;
  logic            tdo_q, tdo_en_q;

  assign tap_rst_n = rst_ni & trst_ni;

  dtap_fsm i_fsm (
    .tck_i(tck_i), .rst_ni(tap_rst_n), .tms_i(tms_i), .state_o(state)
  );

  dtap_ir i_ir (
    .tck_i(tck_i), .rst_ni(tap_rst_n), .state_i(state), .tdi_i(tdi_i),
    .ir_sr_o(ir_sr), .ir_o(ir_q)
  );

  dtap_dr #(.ID_VALUE(ID_VALUE), .USER_W(USER_W)) i_dr (
    .tck_i(tck_i), .rst_ni(tap_rst_n), .state_i(state), .ir_i(ir_q),
    .tdi_i(tdi_i), .stdi_i(stdi_i), .dr_lsb_o(dr_lsb), .user_o(user_dr_o)
  );

  dtap_por #(.POR_CYCLES(POR_CYCLES)) i_por (
    .tck_i(tck_i), .rst_ni(rst_ni), .por_trst_no(por_trst_no)
  );

  always_ff @(negedge tck_i or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= (state == S_SH_IR) ? ir_sr[0] : dr_lsb;
      tdo_en_q <= (state == S_SH_IR) || (state == S_SH_DR);
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_en_o = tdo_en_q;
endmodule

// File: rtl/dtap_checker.sv
module dtap_checker
  import dtap_pkg::*;
#(
  parameter int unsigned POR_CYCLES = 8
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic            tap_rst_n,
  input logic            tms_i,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input logic            tdo_en_o,
  input logic            por_trst_no
);
  localparam int unsigned W = $clog2(POR_CYCLES + 2) + 1;
  logic [W-1:0] edges_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                          edges_q <= '0;
    else if (edges_q != W'(POR_CYCLES + 1)) edges_q <= edges_q + 1'b1;
  end

  p_five_ones_r1: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
      |=> state == S_TLR);

  p_tlr_idcode_r1: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    state == S_TLR |=> ir_q == INS_IDCODE);

  p_ir_capture_r3: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    state == S_CAP_IR |=> ir_sr == IR_CAPTURE);

  p_tdo_en_shift_r8: assert property (@(posedge tck_i) disable iff (!tap_rst_n)
    tdo_en_o == (state == S_SH_IR || state == S_SH_DR));

  p_por_window_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    por_trst_no == (edges_q >= W'(POR_CYCLES)));
endmodule

bind dtap_top dtap_checker #(.POR_CYCLES(POR_CYCLES)) i_chk (
  .tck_i(tck_i), .rst_ni(rst_ni), .tap_rst_n(tap_rst_n), .tms_i(tms_i),
  .state(state), .ir_q(ir_q), .ir_sr(ir_sr), .tdo_en_o(tdo_en_o),
  .por_trst_no(por_trst_no)
);

// File: tb/test_dtap_top.sv
module test_dtap_top;
  localparam int    PERIOD = 10;
  localparam logic [31:0] ID = 32'h1A5C_E0F3;
  localparam int    N = 48;

  logic tck = 1'b0, rst_ni = 1'b0, trst_ni = 1'b1, tms_i = 1'b1, tdi_i = 1'b0, stdi_i = 1'b0;
  logic tdo_o, tdo_en_o, por_trst_no;
  logic [7:0] user_dr_o;
  int checks = 0, fails = 0;
  logic [7:0] user_exp = 8'h00;

  dtap_top #(.ID_VALUE(ID), .USER_W(8), .POR_CYCLES(8)) i_dtap_top (
    .tck_i(tck), .rst_ni(rst_ni), .trst_ni(trst_ni), .tms_i(tms_i), .tdi_i(tdi_i),
    .stdi_i(stdi_i), .tdo_o(tdo_o), .tdo_en_o(tdo_en_o), .user_dr_o(user_dr_o),
    .por_trst_no(por_trst_no)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi, input logic stdi, output logic tdo);
    tms_i = tms; tdi_i = tdi; stdi_i = stdi;
    #(PERIOD/2) tck = 1'b1;
    #(PERIOD/2) tck = 1'b0;
    #1 tdo = tdo_o;
  endtask

  task automatic goto_rti();
    logic t;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
  endtask

  task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
    logic t;
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
    cap[0] = t;
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], ~code[i], t);
      if (i < 3) cap[i+1] = t;
    end
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
  endtask

  task automatic scan_dr(input logic [N-1:0] dv, input logic [N-1:0] sv,
                         output logic [N-1:0] outv);
    logic t;
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
    check("R8 en before shift", {63'd0, tdo_en_o}, 64'd0);
    tick(1'b0, 1'b0, 1'b0, t);
    check("R8 en in shift", {63'd0, tdo_en_o}, 64'd1);
    outv[0] = t;
    for (int i = 0; i < N; i++) begin
      tick(i == N-1, dv[i], sv[i], t);
      if (i < N-1) outv[i+1] = t;
    end
    check("R8 en after shift", {63'd0, tdo_en_o}, 64'd0);
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic t;
    logic [3:0] cap;
    logic [N-1:0] dv, sv, outv, expv;
    #(PERIOD);
    check("R9 por low in reset", {63'd0, por_trst_no}, 64'd0);
    check("R8 en low in reset", {63'd0, tdo_en_o}, 64'd0);
    rst_ni = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      tick(1'b1, 1'b0, 1'b0, t);
      if (k == 7) check("R9 por low at 7", {63'd0, por_trst_no}, 64'd0);
      if (k == 8) check("R9 por high at 8", {63'd0, por_trst_no}, 64'd1);
    end
    goto_rti();
    // reset instruction is IDCODE
    dv = '1; sv = 48'h5A3C_96E1_0F7B;
    scan_dr(dv, sv, outv);
    check("R1 R4 reset idcode", 64'(outv), 64'({sv[15:0], ID}));

    // sweep all instruction codes
    for (int c = 0; c < 16; c++) begin
      scan_ir(4'(c), cap);
      check("R3 ir capture", 64'(cap), 64'h1);
      dv = 48'hC3A5_5E21_96F0 ^ {12{4'(c)}};
      sv = 48'h1E87_F04B_3D69 ^ {12{4'(~c)}};
      scan_dr(dv, sv, outv);
      if (c == 1)
        expv = {sv[15:0], ID};
      else if (c == 2)
        expv = {dv[39:0], user_exp};
      else
        expv = {sv[46:0], 1'b0};
      if (c == 1)      check("R4 idcode from stdi", 64'(outv), 64'(expv));
      else if (c == 2) check("R7 user from tdi", 64'(outv), 64'(expv));
      else if (c == 15) check("R5 bypass from stdi", 64'(outv), 64'(expv));
      else             check("R6 unused acts as bypass", 64'(outv), 64'(expv));
      if (c == 2) begin
        user_exp = dv[N-1 -: 8];
        check("R7 user update", 64'(user_dr_o), 64'(user_exp));
      end
    end
    check("R8 en in rti", {63'd0, tdo_en_o}, 64'd0);

    // user capture of held value, then TMS reset returns IDCODE
    scan_ir(4'b0010, cap);
    dv = 48'h0123_4567_89AB; sv = '0;
    scan_dr(dv, sv, outv);
    check("R7 user capture", 64'(outv[7:0]), 64'(user_exp));
    user_exp = dv[N-1 -: 8];
    goto_rti();
    sv = 48'hFEDC_BA98_7654;
    scan_dr('0, sv, outv);
    check("R1 tms reset idcode", 64'(outv), 64'({sv[15:0], ID}));
    check("R1 user kept", 64'(user_dr_o), 64'(user_exp));

    // asynchronous test reset in the middle of a shift
    scan_ir(4'b0010, cap);
    tick(1'b1, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
    tick(1'b0, 1'b0, 1'b0, t);
    check("R8 en before trst", {63'd0, tdo_en_o}, 64'd1);
    #2 trst_ni = 1'b0;
    #1;
    check("R2 en cleared", {63'd0, tdo_en_o}, 64'd0);
    check("R2 user cleared", 64'(user_dr_o), 64'd0);
    check("R9 por ignores trst", {63'd0, por_trst_no}, 64'd1);
    #2 trst_ni = 1'b1;
    user_exp = 8'h00;
    tick(1'b0, 1'b0, 1'b0, t);
    sv = 48'h0F0F_3333_5555;
    scan_dr('1, sv, outv);
    check("R2 idcode after trst", 64'(outv), 64'({sv[15:0], ID}));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule